// File: doc/BRIEF.md
# Reorder Event Threshold Counter

This block keeps a 16-bit saturating tally of congestion reorder events seen at one switch input port. Each event arrives as a one-cycle strobe. Software picks a threshold. When an increment brings the tally exactly to that threshold, the block latches a sticky status flag. The flag drives a level interrupt through a mask bit.

A zero threshold switches counting off. The tally can be loaded directly through the bus. To return it to zero, software writes one to the status flag, which also clears the flag. This acknowledges the interrupt and re-arms the counter in a single access.

The register bus is a plain single-cycle port. A write is applied on the rising clock edge while `wr_en` is high. Read data is combinational from `addr`. The event strobe and the interrupt are plain control pins, so there is no stream handshake and no back-pressure.

Top module: `reorder_threshold_counter`

## Requirements
- R1: While the threshold is nonzero, each cycle with `evt_strobe` high increments the tally by one on the next clock edge.
- R2: The tally saturates. At 0xFFFF a further event leaves it at 0xFFFF.
- R3: After reset, address 0 reads 0x0000_FFFF, address 1 reads 0, address 2 reads 0, and `irq` is low.
- R4: Address 0 holds the tally in bits 31:16 and the threshold in bits 15:0. A write there loads both fields, and a read returns both.
- R5: While the threshold is 0, events are ignored and the tally keeps its value.
- R6: Status bit 0 at address 1 becomes 1 only on the edge where an event increment makes the tally equal to the threshold.
- R7: Writing address 1 with bit 0 set clears both the status bit and the tally to 0. Writing address 1 with bit 0 clear changes nothing.
- R8: Once set, the status bit holds until it is cleared as in R7.
- R9: `irq` equals the status bit AND the mask bit. The mask is bit 0 at address 2 and is read back there.
- R10: If an event and a status clear fall in the same cycle, the tally ends at 0.
- R11: If an event and a write to address 0 fall in the same cycle, the tally takes the written value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_strobe | input | 1 | One-cycle reorder event pulse |
| addr | input | 2 | Register word address |
| wr_en | input | 1 | Write enable for the current cycle |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Combinational read data for `addr` |
| irq | output | 1 | Level interrupt, status AND mask |

## Verification
Events and register writes take effect on the first rising edge after they are driven, because the tally, threshold, status and mask are each one register stage. `irq` and `rd_data` follow those registers combinationally, so each result is due one edge after its stimulus. The bench drives every input on the falling edge and lets one rising edge pass. At the next falling edge it returns the bus to an idle read of address 0 and samples both outputs, so no check looks at an edge that is still settling.

// File: rtl/evtc_pkg.sv
package evtc_pkg;
  localparam int CNT_W  = 16;
  localparam int DATA_W = 2 * CNT_W;
  localparam int ADDR_W = 2;

  typedef enum logic [ADDR_W-1:0] {
    REG_CNT_THR = 2'd0,
    REG_STATUS  = 2'd1,
    REG_MASK    = 2'd2,
    REG_SPARE   = 2'd3
  } evtc_reg_e;
endpackage

// File: rtl/evtc_counter.sv
module evtc_counter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         evt,
  input  logic         clr,
  input  logic         ld,
  input  logic [W-1:0] ld_cnt,
  input  logic [W-1:0] ld_thr,
  output logic [W-1:0] cnt,
  output logic [W-1:0] thr,
  output logic         hit
);
  localparam logic [W-1:0] CNT_MAX = {W{1'b1}};

  logic         enabled;
  logic         step;
  logic [W-1:0] cnt_inc;

  assign enabled = (thr != '0);
  assign cnt_inc = cnt + 1'b1;
  assign step    = evt && enabled && (cnt != CNT_MAX) && !clr && !ld;
  assign hit     = step && (cnt_inc == thr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      thr <= CNT_MAX;
    end else begin
      if (clr)       cnt <= '0;
      else if (ld)   cnt <= ld_cnt;
      else if (step) cnt <= cnt_inc;
      if (ld) thr <= ld_thr;
    end
  end

  assert_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (evt && thr != '0 && cnt != CNT_MAX && !clr && !ld) |=> (cnt == $past(cnt) + 1'b1));
  assert_saturate_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == CNT_MAX && !clr && !ld) |=> (cnt == CNT_MAX));
  assert_disabled_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (thr == '0 && !clr && !ld) |=> $stable(cnt));
  assert_clear_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cnt == '0));
  assert_load_wins_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (ld && !clr) |=> (cnt == $past(ld_cnt)));
endmodule

// File: rtl/evtc_irq.sv
module evtc_irq (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  input  logic mask_wr,
  input  logic mask_d,
  output logic stat,
  output logic mask,
  output logic irq
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat <= 1'b0;
      mask <= 1'b0;
    end else begin
      if (clr)      stat <= 1'b0;
      else if (set) stat <= 1'b1;
      if (mask_wr) mask <= mask_d;
    end
  end

  assign irq = stat & mask;

  assert_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (set && !clr) |=> stat);
  assert_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (stat && !clr) |=> stat);
  assert_no_spurious_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!stat && !set) |=> !stat);
endmodule

// File: rtl/evtc_decode.sv
module evtc_decode
  import evtc_pkg::*;
(
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [CNT_W-1:0]  cnt,
  input  logic [CNT_W-1:0]  thr,
  input  logic              stat,
  input  logic              mask,
  output logic              cnt_ld,
  output logic              stat_clr,
  output logic              mask_wr,
  output logic [DATA_W-1:0] rd_data
);
  assign cnt_ld   = wr_en && (addr == REG_CNT_THR);
  assign stat_clr = wr_en && (addr == REG_STATUS) && wr_data[0];
  assign mask_wr  = wr_en && (addr == REG_MASK);

  always_comb begin
    rd_data = '0;
    case (addr)
      REG_CNT_THR: rd_data = {cnt, thr};
      REG_STATUS:  rd_data[0] = stat;
      REG_MASK:    rd_data[0] = mask;
      default:     rd_data = '0;
    endcase
  end
endmodule

// File: rtl/reorder_threshold_counter.sv
module reorder_threshold_counter
  import evtc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              evt_strobe,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  output logic              irq
);
  logic [CNT_W-1:0] cnt, thr;
  logic             hit, stat, mask;
  logic             cnt_ld, stat_clr, mask_wr;

  evtc_decode u_dec (
    .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
    .cnt(cnt), .thr(thr), .stat(stat), .mask(mask),
    .cnt_ld(cnt_ld), .stat_clr(stat_clr), .mask_wr(mask_wr), .rd_data(rd_data)
  );

  evtc_counter #(.W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .evt(evt_strobe), .clr(stat_clr), .ld(cnt_ld),
    .ld_cnt(wr_data[DATA_W-1:CNT_W]), .ld_thr(wr_data[CNT_W-1:0]),
    .cnt(cnt), .thr(thr), .hit(hit)
  );

  evtc_irq u_irq (
    .clk(clk), .rst_n(rst_n), .set(hit), .clr(stat_clr),
    .mask_wr(mask_wr), .mask_d(wr_data[0]),
    .stat(stat), .mask(mask), .irq(irq)
  );

  assert_irq_gate_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_wr && !wr_data[0]) |=> !irq);
  assert_w1c_R7: assert property (@(posedge clk) disable iff (!rst_n)
    stat_clr |=> (!irq && rd_data[DATA_W-1:CNT_W] == '0 || addr != REG_CNT_THR || cnt_ld == 1'b1 || !irq));
endmodule

// File: tb/sim_reorder_threshold_counter.sv
module sim_reorder_threshold_counter;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 19;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        evt_strobe = 1'b0;
  logic [1:0]  addr = 2'd0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic        irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  reorder_threshold_counter u0 (
    .clk(clk), .rst_n(rst_n), .evt_strobe(evt_strobe), .addr(addr),
    .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data), .irq(irq)
  );

  // {evt, wr, addr, wdata, expected word at address 0, expected irq}
  localparam logic [68:0] VEC [NV] = '{
    {1'b0, 1'b1, 2'd2, 32'h0000_0001, 32'h0000_FFFF, 1'b0}, // R9 unmask
    {1'b0, 1'b1, 2'd0, 32'h0000_0003, 32'h0000_0003, 1'b0}, // R4 load
    {1'b1, 1'b0, 2'd0, 32'h0,         32'h0001_0003, 1'b0}, // R1
    {1'b1, 1'b0, 2'd0, 32'h0,         32'h0002_0003, 1'b0}, // R1
    {1'b1, 1'b0, 2'd0, 32'h0,         32'h0003_0003, 1'b1}, // R6 hit
    {1'b1, 1'b0, 2'd0, 32'h0,         32'h0004_0003, 1'b1}, // R8 sticky
    {1'b0, 1'b1, 2'd1, 32'h0000_0000, 32'h0004_0003, 1'b1}, // R7 write 0
    {1'b0, 1'b1, 2'd1, 32'h0000_0001, 32'h0000_0003, 1'b0}, // R7 clear
    {1'b0, 1'b1, 2'd0, 32'h0005_0000, 32'h0005_0000, 1'b0}, // R4
    {1'b1, 1'b0, 2'd0, 32'h0,         32'h0005_0000, 1'b0}, // R5
    {1'b0, 1'b1, 2'd0, 32'hFFFE_0002, 32'hFFFE_0002, 1'b0}, // R4
    {1'b1, 1'b0, 2'd0, 32'h0,         32'hFFFF_0002, 1'b0}, // R1 no hit
    {1'b1, 1'b0, 2'd0, 32'h0,         32'hFFFF_0002, 1'b0}, // R2
    {1'b1, 1'b1, 2'd1, 32'h0000_0001, 32'h0000_0002, 1'b0}, // R10
    {1'b1, 1'b1, 2'd0, 32'h0010_0002, 32'h0010_0002, 1'b0}, // R11
    {1'b0, 1'b1, 2'd0, 32'h0001_0002, 32'h0001_0002, 1'b0}, // R4
    {1'b0, 1'b1, 2'd2, 32'h0000_0000, 32'h0001_0002, 1'b0}, // R9 mask
    {1'b1, 1'b0, 2'd0, 32'h0,         32'h0002_0002, 1'b0}, // R9 masked hit
    {1'b0, 1'b1, 2'd2, 32'h0000_0001, 32'h0002_0002, 1'b1}  // R9 unmask
  };

  task automatic check32(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic read_at(input logic [1:0] a, output logic [31:0] v);
    addr = a;
    #1;
    v = rd_data;
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    // R3 reset state
    read_at(2'd0, v); check32("R3 word0", v, 32'h0000_FFFF);
    read_at(2'd1, v); check32("R3 status", v, 32'h0);
    read_at(2'd2, v); check32("R3 mask", v, 32'h0);
    check32("R3 irq", {31'h0, irq}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      evt_strobe = VEC[i][68];
      wr_en      = VEC[i][67];
      addr       = VEC[i][66:65];
      wr_data    = VEC[i][64:33];
      @(negedge clk);
      evt_strobe = 1'b0;
      wr_en      = 1'b0;
      wr_data    = '0;
      read_at(2'd0, v);
      check32($sformatf("vec%0d word0 R1/R2/R4/R5/R7/R10/R11", i), v, VEC[i][32:1]);
      check32($sformatf("vec%0d irq R6/R8/R9", i), {31'h0, irq}, {31'h0, VEC[i][0]});
      @(negedge clk);
    end

    // R8 and R9 readback through the bus
    read_at(2'd1, v); check32("R8 status held", v, 32'h1);
    read_at(2'd2, v); check32("R9 mask readback", v, 32'h1);

    // R6: threshold 0xFFFF is reached exactly at saturation
    addr = 2'd1; wr_en = 1'b1; wr_data = 32'h1;
    @(negedge clk);
    addr = 2'd0; wr_data = 32'hFFFE_FFFF;
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0;
    read_at(2'd1, v); check32("R6 status before hit", v, 32'h0);
    evt_strobe = 1'b1;
    @(negedge clk);
    evt_strobe = 1'b0;
    read_at(2'd1, v); check32("R6 status at 0xFFFF", v, 32'h1);
    read_at(2'd0, v); check32("R2 word0", v, 32'hFFFF_FFFF);

    // R3 reset again mid-run
    rst_n = 1'b0;
    #1;
    read_at(2'd0, v); check32("R3 word0 after reset", v, 32'h0000_FFFF);
    check32("R3 irq after reset", {31'h0, irq}, 32'h0);
    finish_run();
  end
endmodule